// File: doc/BRIEF.md
# Displaced 32-bit Pointer Load Sequencer

This block carries out one memory-to-register move: it fills one of four 32-bit pointer registers with a word taken from memory. The word's address is another pointer register plus a signed 8-bit offset. Instruction fetch is done elsewhere. The block receives three bytes from the fetch logic:

- an escape byte,
- an operation byte that names the target and base registers,
- the offset byte.

The block adds the base to the offset. It then decides whether the access goes to the translation unit or straight to physical memory. It fetches the four bytes over a request/acknowledge bus and places the assembled word in the target register in a single update.

An access is tagged for translation when the upper half of the base register is all ones. Any other base gives a physical access, and the address is cut down to the installed memory width: 20 or 24 bits, chosen by a configuration pin. The bus moves either one byte per beat or, in enhanced mode with a wide bus, two bytes per beat when the beat address is even. The instruction always takes a fixed number of cycles. That number depends on the mode, the bus width and the address parity. The sequencer pads with idle cycles when memory answers sooner than the budget.

The register file can also be loaded and read from a side port. The surrounding core uses this port to set pointers and to observe results.

Top module: `ptr_load_seq`

## Requirements
- R1: A start is legal when the escape byte is 0x6D and the operation byte's bits 3:0 equal 0x8. Bits 7:6 of the operation byte pick the target register and bits 5:4 pick the base register. The codes 0, 1, 2 and 3 map to register index 0, 1, 2 and 3 of the side port.
- R2: The effective address equals the base register plus the offset byte, sign-extended to 32 bits (0x80 to 0xFF mean -128 to -1).
- R3: Target byte k (bits 8k+7:8k) is the byte at effective address + k, for k = 0 to 3.
- R4: When base bits 31:16 are all ones, every beat raises mem_logical and drives the full unmasked 32-bit address.
- R5: Otherwise mem_logical stays low and each beat address is (effective address + k) masked to its low 20 bits (phys24=0) or low 24 bits (phys24=1).
- R6: On a byte-wide path with zero-wait memory, busy stays high for exactly 15 cycles in legacy mode (mode_enh=0, whatever bus16 is) and exactly 16 cycles in enhanced byte-bus mode.
- R7: In enhanced mode with bus16=1, busy lasts 14 cycles for an even effective address and 15 cycles for an odd one. On a wide beat (mem_wide=1), mem_rdata[7:0] holds the byte at mem_addr and mem_rdata[15:8] holds the byte at mem_addr+1.
- R8: When the target is also the base, the address comes from the old base value. The target register keeps its old value until the operation completes.
- R9: An illegal start produces a one-cycle illegal pulse in the next cycle, starts no access and leaves all four registers unchanged.
- R10: done pulses for exactly one cycle, in the cycle right after the last busy cycle. The new register value is visible from that cycle onward.
- R11: A start presented while busy is high is ignored. It causes no illegal pulse, does not lengthen the operation and does not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept the three instruction bytes this cycle |
| prefix | input | 8 | Escape byte |
| opcode | input | 8 | Operation byte with register selects |
| disp | input | 8 | Signed offset |
| mode_enh | input | 1 | Enhanced timing mode |
| bus16 | input | 1 | Wide data bus fitted (used only in enhanced mode) |
| phys24 | input | 1 | Installed physical width: 1 = 24 bits, 0 = 20 bits |
| mem_req | output | 1 | Read beat requested |
| mem_addr | output | 32 | Beat address |
| mem_logical | output | 1 | Beat address needs translation |
| mem_wide | output | 1 | Beat reads two bytes |
| mem_ack | input | 1 | Beat complete; data valid |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished; register written |
| illegal | output | 1 | Illegal start seen |
| host_we | input | 1 | Side-port register write |
| host_sel | input | 2 | Side-port write index |
| host_wdata | input | 32 | Side-port write data |
| host_rsel | input | 2 | Side-port read index |
| host_rdata | output | 32 | Side-port read data |

## Verification
The hardest case to reach from the ports is the odd-address wide path in which the beat addresses also wrap across the top of the physical window. Here a byte beat, a wide beat and another byte beat must land on the right target lanes, and the masked addresses must restart at zero. The stimulus reaches it by loading the base through the side port with 0x00FFFFFE and using offset +1 with phys24 set. A second vector wraps a 20-bit window on the legacy path. Self-targeting loads and starts injected in the middle of an operation cover the atomic-update and ignore rules.

// File: rtl/ptr_load_pkg.sv
package ptr_load_pkg;
    localparam int PTR_W = 32;
    localparam int NREG  = 4;
    localparam int SEL_W = $clog2(NREG);
    localparam int CNT_W = 5;
    localparam int NBYTE = PTR_W / 8;

    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_PAD} seq_st_e;

    typedef struct packed {
        seq_st_e                    st;
        logic [CNT_W-1:0]           cnt;
        logic [CNT_W-1:0]           budget;
        logic [PTR_W-1:0]           ea;
        logic [2:0]                 off;
        logic [NBYTE-1:0][7:0]      acc;
        logic [SEL_W-1:0]           dst;
        logic                       logical;
        logic                       wide;
        logic                       done;
        logic                       illegal;
    } seq_state_t;
endpackage

// File: rtl/ptr_regfile.sv
module ptr_regfile
    import ptr_load_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seq_we,
    input  logic [SEL_W-1:0] seq_sel,
    input  logic [PTR_W-1:0] seq_data,
    input  logic             host_we,
    input  logic [SEL_W-1:0] host_sel,
    input  logic [PTR_W-1:0] host_data,
    input  logic [SEL_W-1:0] ra_sel,
    output logic [PTR_W-1:0] ra_data,
    input  logic [SEL_W-1:0] rb_sel,
    output logic [PTR_W-1:0] rb_data
);
    logic [NREG-1:0][PTR_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NREG; i++) begin
            if (seq_we && seq_sel == SEL_W'(i)) begin
                regs_d[i] = seq_data;
            end else if (host_we && host_sel == SEL_W'(i)) begin
                regs_d[i] = host_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ra_data = regs_q[ra_sel];
    assign rb_data = regs_q[rb_sel];
endmodule

// File: rtl/ptr_decode.sv
module ptr_decode
    import ptr_load_pkg::*;
#(
    parameter logic [7:0] PREFIX_CODE = 8'h6D,
    parameter int         PHYS_LO_W   = 20,
    parameter int         PHYS_HI_W   = 24
) (
    input  logic [7:0]       prefix,
    input  logic [7:0]       opcode,
    input  logic [7:0]       disp,
    input  logic [PTR_W-1:0] base_val,
    input  logic             phys24,
    output logic             legal,
    output logic [SEL_W-1:0] dst_sel,
    output logic [SEL_W-1:0] base_sel,
    output logic [PTR_W-1:0] ea,
    output logic             logical,
    output logic [PTR_W-1:0] phys_mask
);
    localparam int              HALF    = PTR_W / 2;
    localparam logic [PTR_W-1:0] MASK_LO = PTR_W'((64'd1 << PHYS_LO_W) - 64'd1);
    localparam logic [PTR_W-1:0] MASK_HI = PTR_W'((64'd1 << PHYS_HI_W) - 64'd1);

    assign legal     = (prefix == PREFIX_CODE) && (opcode[3:0] == 4'h8);
    assign dst_sel   = opcode[7:6];
    assign base_sel  = opcode[5:4];
    assign ea        = base_val + {{(PTR_W-8){disp[7]}}, disp};
    assign logical   = &base_val[PTR_W-1:HALF];
    assign phys_mask = phys24 ? MASK_HI : MASK_LO;
endmodule

// File: rtl/ptr_load_seq.sv
module ptr_load_seq
    import ptr_load_pkg::*;
#(
    parameter logic [7:0] PREFIX_CODE = 8'h6D,
    parameter int         PHYS_LO_W   = 20,
    parameter int         PHYS_HI_W   = 24,
    parameter int         CYC_LEGACY  = 15,
    parameter int         CYC_ENH8    = 16,
    parameter int         CYC_ODD16   = 15,
    parameter int         CYC_EVEN16  = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  prefix,
    input  logic [7:0]  opcode,
    input  logic [7:0]  disp,
    input  logic        mode_enh,
    input  logic        bus16,
    input  logic        phys24,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    output logic        mem_logical,
    output logic        mem_wide,
    input  logic        mem_ack,
    input  logic [15:0] mem_rdata,
    output logic        busy,
    output logic        done,
    output logic        illegal,
    input  logic        host_we,
    input  logic [1:0]  host_sel,
    input  logic [31:0] host_wdata,
    input  logic [1:0]  host_rsel,
    output logic [31:0] host_rdata
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    seq_state_t       q, d;
    logic             legal, logical, seq_we, piece_wide;
    logic [SEL_W-1:0] dst_sel, base_sel;
    logic [PTR_W-1:0] ea, base_val, phys_mask, piece_addr;

    ptr_regfile u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .seq_we   (seq_we),
        .seq_sel  (q.dst),
        .seq_data (d.acc),
        .host_we  (host_we),
        .host_sel (host_sel),
        .host_data(host_wdata),
        .ra_sel   (base_sel),
        .ra_data  (base_val),
        .rb_sel   (host_rsel),
        .rb_data  (host_rdata)
    );

    ptr_decode #(
        .PREFIX_CODE(PREFIX_CODE),
        .PHYS_LO_W  (PHYS_LO_W),
        .PHYS_HI_W  (PHYS_HI_W)
    ) u_dec (
        .prefix   (prefix),
        .opcode   (opcode),
        .disp     (disp),
        .base_val (base_val),
        .phys24   (phys24),
        .legal    (legal),
        .dst_sel  (dst_sel),
        .base_sel (base_sel),
        .ea       (ea),
        .logical  (logical),
        .phys_mask(phys_mask)
    );

    // Current beat: a wide beat needs an even address and two bytes still owed.
    assign piece_addr = q.ea + PTR_W'(q.off);
    assign piece_wide = q.wide && !piece_addr[0] && (q.off <= 3'd2);

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.illegal = 1'b0;
        seq_we    = 1'b0;
        if (q.st != ST_IDLE && q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (legal) begin
                        d.st      = ST_READ;
                        d.cnt     = CNT_W'(1);
                        d.ea      = ea;
                        d.off     = 3'd0;
                        d.acc     = '0;
                        d.dst     = dst_sel;
                        d.logical = logical;
                        d.wide    = mode_enh && bus16;
                        if (!mode_enh)  d.budget = CNT_W'(CYC_LEGACY);
                        else if (!bus16) d.budget = CNT_W'(CYC_ENH8);
                        else if (ea[0]) d.budget = CNT_W'(CYC_ODD16);
                        else            d.budget = CNT_W'(CYC_EVEN16);
                    end else begin
                        d.illegal = 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    d.acc[q.off[1:0]] = mem_rdata[7:0];
                    if (piece_wide) d.acc[q.off[1:0] + 2'd1] = mem_rdata[15:8];
                    d.off = q.off + (piece_wide ? 3'd2 : 3'd1);
                    if (d.off == 3'd4) begin
                        if (q.cnt >= q.budget) begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                            seq_we = 1'b1;
                        end else begin
                            d.st = ST_PAD;
                        end
                    end
                end
            end
            ST_PAD: begin
                if (q.cnt >= q.budget) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    seq_we = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.st != ST_IDLE);
    assign mem_req     = (q.st == ST_READ);
    assign mem_addr    = q.logical ? piece_addr : (piece_addr & phys_mask);
    assign mem_logical = mem_req && q.logical;
    assign mem_wide    = mem_req && piece_wide;
    assign done        = q.done;
    assign illegal     = q.illegal;
endmodule

// File: rtl/ptr_load_seq_chk.sv
module ptr_load_seq_chk #(
    parameter int MIN_CYC = 14
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [7:0]  opcode,
    input logic        busy,
    input logic        done,
    input logic        illegal,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_logical,
    input logic        phys24
);
    logic [7:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                    run_q <= '0;
        else if (!busy)                run_q <= '0;
        else if (run_q != 8'hFF)       run_q <= run_q + 8'd1;
    end

    // R5: physical beats stay inside the installed window
    a_r5_phys_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_logical) |->
            (phys24 ? (mem_addr[31:24] == 8'h00) : (mem_addr[31:20] == 12'h000)));

    // R4: translation tag does not change between consecutive beats
    a_r4_logical_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> $stable(mem_logical));

    // R9: illegal start answered next cycle without starting work
    a_r9_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && opcode[3:0] != 4'h8) |=> (illegal && !busy));

    // R10: done is a single-cycle pulse after a busy run
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && run_q >= 8'(MIN_CYC)));

    // R11: start during an operation raises no illegal pulse
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !illegal);

    // R6: beats are only issued while an operation runs
    a_r6_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
endmodule

bind ptr_load_seq ptr_load_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .opcode     (opcode),
    .busy       (busy),
    .done       (done),
    .illegal    (illegal),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_logical(mem_logical),
    .phys24     (phys24)
);

// File: tb/ptr_load_seq_tb_top.sv
`timescale 1ns/1ps
module ptr_load_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  prefix = 8'h6D, opcode = 8'h08, disp = 8'h00;
    logic        mode_enh = 1'b0, bus16 = 1'b0, phys24 = 1'b1;
    logic        mem_req, mem_logical, mem_wide, mem_ack;
    logic [31:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        busy, done, illegal;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0, host_rsel = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] mb(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'hA5 ^ {a[3:0], a[7:4]};
    endfunction

    assign mem_ack   = mem_req;
    assign mem_rdata = mem_wide ? {mb(mem_addr + 32'd1), mb(mem_addr)} : {8'h00, mb(mem_addr)};

    ptr_load_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .prefix(prefix), .opcode(opcode),
        .disp(disp), .mode_enh(mode_enh), .bus16(bus16), .phys24(phys24),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_logical(mem_logical),
        .mem_wide(mem_wide), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .illegal(illegal),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .host_rsel(host_rsel), .host_rdata(host_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = val;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] val);
        host_rsel = sel;
        #1;
        val = host_rdata;
    endtask

    function automatic logic [31:0] base_of(input int i);
        return 32'h1111_1111 * (i + 1);
    endfunction

    task automatic preload(input logic [1:0] bsel, input logic [31:0] bval);
        for (int i = 0; i < 4; i++) wr(2'(i), base_of(i));
        wr(bsel, bval);
    endtask

    // Issue a start; count busy cycles; optionally poke an extra start mid-run.
    task automatic run(input logic [7:0] op, input logic [7:0] dd, input int poke,
                       input logic [1:0] watch, output int cyc, output logic slog,
                       output logic bad, output logic [31:0] mid, output logic sawill,
                       output int done_w);
        logic [31:0] mask;
        int guard;
        mask = phys24 ? 32'h00FF_FFFF : 32'h000F_FFFF;
        @(negedge clk);
        prefix = 8'h6D; opcode = op; disp = dd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        host_rsel = watch;
        cyc = 0; slog = 1'b0; bad = 1'b0; sawill = 1'b0; mid = '0; guard = 0; done_w = 0;
        while (!done && guard < 200) begin
            if (busy) cyc++;
            if (mem_req && mem_logical) slog = 1'b1;
            if (mem_req && !mem_logical && ((mem_addr & ~mask) != 0)) bad = 1'b1;
            if (illegal) sawill = 1'b1;
            if (cyc == 3) mid = host_rdata;
            if (cyc == poke) begin opcode = 8'h09; start = 1'b1; end
            else start = 1'b0;
            guard++;
            @(negedge clk);
        end
        start = 1'b0;
        while (done && guard < 200) begin done_w++; guard++; @(negedge clk); end
    endtask

    typedef struct packed {
        logic [7:0]  op;
        logic [7:0]  d;
        logic [31:0] sv;
        logic        enh;
        logic        b16;
        logic        m24;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'h08, 8'h04, 32'h0000_1000, 1'b0, 1'b0, 1'b1},
        '{8'h18, 8'hFC, 32'h0001_0003, 1'b1, 1'b1, 1'b1},
        '{8'h68, 8'h10, 32'hFFFF_1230, 1'b1, 1'b1, 1'b1},
        '{8'hB8, 8'h7F, 32'h12F0_0001, 1'b1, 1'b0, 1'b0},
        '{8'hC8, 8'h80, 32'h0AB0_0100, 1'b1, 1'b1, 1'b1},
        '{8'hF8, 8'h02, 32'hFFFF_FFFE, 1'b1, 1'b1, 1'b1},
        '{8'h98, 8'h01, 32'h000F_FFFF, 1'b0, 1'b1, 1'b0},
        '{8'hA8, 8'h01, 32'h0000_2000, 1'b1, 1'b1, 1'b1},
        '{8'h48, 8'h01, 32'h00FF_FFFE, 1'b1, 1'b1, 1'b1}
    };

    initial begin
        #(200000 * 8);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v, ea, exp, mask, mid;
        logic [1:0]  bs, ds;
        logic        lg, slog, bad, sawill;
        int          cyc, ecyc, dw;

        repeat (3) @(negedge clk);
        // Reset state
        chk("R10 reset busy", 32'(busy), 32'd0);
        chk("R10 reset done", 32'(done), 32'd0);
        chk("R9 reset illegal", 32'(illegal), 32'd0);
        chk("R6 reset mem_req", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin rd(2'(i), v); chk("R1 reset reg", v, 32'd0); end

        // Vector table
        for (int k = 0; k < NV; k++) begin
            mode_enh = VECS[k].enh; bus16 = VECS[k].b16; phys24 = VECS[k].m24;
            bs = VECS[k].op[5:4]; ds = VECS[k].op[7:6];
            preload(bs, VECS[k].sv);
            ea   = VECS[k].sv + {{24{VECS[k].d[7]}}, VECS[k].d};
            lg   = &VECS[k].sv[31:16];
            mask = VECS[k].m24 ? 32'h00FF_FFFF : 32'h000F_FFFF;
            for (int b = 0; b < 4; b++)
                exp[8*b +: 8] = mb(lg ? ea + 32'(b) : ((ea + 32'(b)) & mask));
            ecyc = !VECS[k].enh ? 15 : (!VECS[k].b16 ? 16 : (ea[0] ? 15 : 14));
            run(VECS[k].op, VECS[k].d, -1, ds, cyc, slog, bad, mid, sawill, dw);
            chk(VECS[k].b16 && VECS[k].enh ? "R7 cycle budget" : "R6 cycle budget", 32'(cyc), 32'(ecyc));
            chk("R4 logical tag", 32'(slog), 32'(lg));
            chk("R5 physical mask", 32'(bad), 32'd0);
            chk("R10 done width", 32'(dw), 32'd1);
            chk("R8 target held mid-run", mid, (ds == bs) ? VECS[k].sv : base_of(ds));
            for (int i = 0; i < 4; i++) begin
                rd(2'(i), v);
                if (2'(i) == ds)      chk("R2 R3 loaded value", v, exp);
                else if (2'(i) == bs) chk("R1 base untouched", v, VECS[k].sv);
                else                  chk("R1 other untouched", v, base_of(i));
            end
        end

        // Illegal low nibble
        mode_enh = 1'b0; bus16 = 1'b0; phys24 = 1'b1;
        preload(2'd1, 32'h0000_4000);
        @(negedge clk);
        prefix = 8'h6D; opcode = 8'h09; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 illegal pulse", 32'(illegal), 32'd1);
        chk("R9 no busy", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R9 pulse ends", 32'(illegal), 32'd0);
        chk("R9 no request", 32'(mem_req), 32'd0);
        // Wrong escape byte
        prefix = 8'h6C; opcode = 8'h08; start = 1'b1;
        @(negedge clk);
        start = 1'b0; prefix = 8'h6D;
        chk("R1 wrong escape flagged", 32'(illegal), 32'd1);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), v);
            chk("R9 regs unchanged", v, (i == 1) ? 32'h0000_4000 : base_of(i));
        end

        // Start during busy is ignored
        mode_enh = 1'b1; bus16 = 1'b1; phys24 = 1'b1;
        preload(2'd2, 32'h0000_3000);
        run(8'hE8, 8'h00, 5, 2'd3, cyc, slog, bad, mid, sawill, dw);
        chk("R11 no illegal", 32'(sawill), 32'd0);
        chk("R11 budget kept", 32'(cyc), 32'd14);
        rd(2'd3, v);
        exp = {mb(32'h3003), mb(32'h3002), mb(32'h3001), mb(32'h3000)};
        chk("R11 result kept", v, exp);
        repeat (3) @(negedge clk);
        chk("R11 no restart", 32'(busy), 32'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule